// File: doc/BRIEF.md
# Dual-Reservation Store-Conditional Unit

This block lets a core update two memory words as one atomic step, which gives a double compare-and-swap. Software opens a sequence with a load-linked, which reserves a first address. A pipelined load-linked then reserves a second address. A pipelined store-conditional to the second address does not write memory. If it succeeds, its address and data wait in a pending buffer. A closing store-conditional to the first address then writes both words in the same cycle, but only if neither reserved cache line has been disturbed.

A snoop port reports writes and invalidations from other agents by byte address. Any snoop whose cache line matches a live reservation drops that reservation. Every store-conditional gets a registered pass/fail answer one cycle after its request. A failed inner store-conditional dooms the outer one. The data cache, load path, register file and interlocks are outside this block.

Top module: `dual_link_commit`

## Requirements
- R1: After reset, and after a reset applied in the middle of a sequence, `res_valid`, `res_ok`, `wr_en` and `wr_pair` are 0, and a following store-conditional fails.
- R2: Op codes on `req_op` are 0 = load-linked, 1 = pipelined load-linked, 2 = pipelined store-conditional and 3 = store-conditional. A load-linked to address A followed by a store-conditional to A, with no disturbing snoop, gives `res_ok`=1 and `wr_en`=1 with `wr_pair`=0, `wr_addr0`=A and `wr_data0` equal to the store data. All of these appear one cycle after the store-conditional request.
- R3: For the sequence load-linked A, pipelined load-linked B, pipelined store-conditional B, store-conditional A:
  - the pipelined store-conditional reports `res_ok`=1 and issues no write;
  - the store-conditional then raises `wr_en` and `wr_pair` together in one cycle, with `wr_addr0`/`wr_data0` from its own request and `wr_addr1`/`wr_data1` from the buffered pipelined store.
- R4: A snoop whose line address (byte address with the low log2(LINE_BYTES) bits dropped) equals reservation A's line makes the store-conditional fail with no write. A snoop to a different line has no effect.
- R5: A snoop to the line of B that arrives after a successful pipelined store-conditional makes the store-conditional fail, and neither word is written.
- R6: A failed pipelined store-conditional reports `res_ok`=0. The following store-conditional also fails, even though reservation A is intact.
- R7: A store-conditional whose address differs from the linked address fails. A second store-conditional issued after any store-conditional fails, because all reservations are cleared.
- R8: A pipelined load-linked issued with no open load-linked sequence is ignored, so a following pipelined store-conditional fails.
- R9: A new load-linked clears the pending store and any earlier inner failure, so a store-conditional that follows it can succeed with a single write.
- R10: `res_valid` is 1 exactly in the cycle after each store-conditional or pipelined store-conditional request and 0 otherwise. `res_ok` is 1 for success and 0 for failure.
- R11: A snoop to reservation A's line in the same cycle as the store-conditional request makes that store-conditional fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Pipeline request strobe |
| req_op | input | 2 | Operation code (see R2) |
| req_addr | input | AW | Request byte address |
| req_data | input | DW | Store data |
| snoop_valid | input | 1 | Remote write or invalidation strobe |
| snoop_addr | input | AW | Byte address of the remote access |
| res_valid | output | 1 | Store-conditional result strobe |
| res_ok | output | 1 | 1 on success, 0 on failure |
| wr_en | output | 1 | Memory write commit |
| wr_pair | output | 1 | Second write is part of this commit |
| wr_addr0 | output | AW | Address of the outer store |
| wr_data0 | output | DW | Data of the outer store |
| wr_addr1 | output | AW | Address of the buffered store |
| wr_data1 | output | DW | Data of the buffered store |

## Verification
The hardest case to reach from the ports is a line that is disturbed after the inner store has already been accepted into the pending buffer. This checks that a buffered store is thrown away rather than written. The stimulus reaches this case with a full four-step sequence and a snoop to the second line, placed between the successful pipelined store-conditional and the closing store-conditional. Same-cycle snoop collisions, and snoops to a neighbouring line that must leave the reservation intact, are driven as separate table rows.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [1:0] {
    OP_LINK  = 2'd0,
    OP_LINK2 = 2'd1,
    OP_COND2 = 2'd2,
    OP_COND  = 2'd3
  } dlc_op_e;
endpackage

// File: rtl/dlc_rsv_slot.sv
module dlc_rsv_slot #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [AW-1:0] addr_i,
  input  logic          snoop_valid_i,
  input  logic [AW-1:0] snoop_addr_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic          intact_o
);
  localparam int OFFW = $clog2(LINE_BYTES);

  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q;
  logic          snoop_hit;

  assign snoop_hit = snoop_valid_i &&
                     (snoop_addr_i[AW-1:OFFW] == addr_q[AW-1:OFFW]);

  // set wins over clear, clear wins over snoop loss
  always_comb begin
    valid_d = valid_q;
    if (set_i)          valid_d = 1'b1;
    else if (clr_i)     valid_d = 1'b0;
    else if (snoop_hit) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (set_i) addr_q <= addr_i;
    end
  end

  assign valid_o  = valid_q;
  assign addr_o   = addr_q;
  assign intact_o = valid_q && !snoop_hit;
endmodule

// File: rtl/dlc_pend_buf.sv
module dlc_pend_buf #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          clr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_comb begin
    valid_d = valid_q;
    if (clr_i)       valid_d = 1'b0;
    else if (load_i) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load_i) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
endmodule

// File: rtl/dual_link_commit.sv
module dual_link_commit #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  output logic          res_valid,
  output logic          res_ok,
  output logic          wr_en,
  output logic          wr_pair,
  output logic [AW-1:0] wr_addr0,
  output logic [DW-1:0] wr_data0,
  output logic [AW-1:0] wr_addr1,
  output logic [DW-1:0] wr_data1
);
  import dlc_pkg::*;

  localparam int NRSV = 2;

  dlc_op_e op;
  logic    is_ll, is_llp, is_scp, is_sc;
  logic    scp_ok, sc_ok;

  logic [NRSV-1:0]          rsv_set, rsv_clr, rsv_valid, rsv_intact;
  logic [NRSV-1:0][AW-1:0]  rsv_addr;

  logic          open_q, open_d;
  logic          ifail_q, ifail_d;
  logic          pend_v;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;

  assign op     = dlc_op_e'(req_op);
  assign is_ll  = req_valid && (op == OP_LINK);
  assign is_llp = req_valid && (op == OP_LINK2) && open_q;
  assign is_scp = req_valid && (op == OP_COND2);
  assign is_sc  = req_valid && (op == OP_COND);

  // slot 0 follows the outer link, slot 1 the pipelined link
  assign rsv_set[0] = is_ll;
  assign rsv_clr[0] = is_sc;
  assign rsv_set[1] = is_llp;
  assign rsv_clr[1] = is_ll || is_sc;

  for (genvar g = 0; g < NRSV; g++) begin : g_rsv
    dlc_rsv_slot #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_slot (
      .clk           (clk),
      .rst_n         (rst_n),
      .set_i         (rsv_set[g]),
      .clr_i         (rsv_clr[g]),
      .addr_i        (req_addr),
      .snoop_valid_i (snoop_valid),
      .snoop_addr_i  (snoop_addr),
      .valid_o       (rsv_valid[g]),
      .addr_o        (rsv_addr[g]),
      .intact_o      (rsv_intact[g])
    );
  end

  dlc_pend_buf #(.AW(AW), .DW(DW)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (scp_ok),
    .clr_i   (is_ll || is_sc),
    .addr_i  (req_addr),
    .data_i  (req_data),
    .valid_o (pend_v),
    .addr_o  (pend_addr),
    .data_o  (pend_data)
  );

  assign scp_ok = is_scp && rsv_intact[0] && rsv_intact[1] &&
                  (req_addr == rsv_addr[1]) && !ifail_q;
  assign sc_ok  = is_sc && rsv_intact[0] && (req_addr == rsv_addr[0]) &&
                  !ifail_q && (!pend_v || rsv_intact[1]);

  always_comb begin
    open_d  = open_q;
    ifail_d = ifail_q;
    if (is_ll) begin
      open_d  = 1'b1;
      ifail_d = 1'b0;
    end else if (is_sc) begin
      open_d  = 1'b0;
      ifail_d = 1'b0;
    end else if (is_scp && !scp_ok) begin
      ifail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      ifail_q   <= 1'b0;
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
      wr_en     <= 1'b0;
      wr_pair   <= 1'b0;
      wr_addr0  <= '0;
      wr_data0  <= '0;
      wr_addr1  <= '0;
      wr_data1  <= '0;
    end else begin
      open_q    <= open_d;
      ifail_q   <= ifail_d;
      res_valid <= is_scp || is_sc;
      res_ok    <= scp_ok || sc_ok;
      wr_en     <= sc_ok;
      wr_pair   <= sc_ok && pend_v;
      if (sc_ok) begin
        wr_addr0 <= req_addr;
        wr_data0 <= req_data;
      end
      if (sc_ok && pend_v) begin
        wr_addr1 <= pend_addr;
        wr_data1 <= pend_data;
      end
    end
  end

  logic unused_ok;
  assign unused_ok = ^rsv_valid;
endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_BYTES = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic          snoop_valid,
  input logic [AW-1:0] snoop_addr,
  input logic          res_valid,
  input logic          res_ok,
  input logic          wr_en,
  input logic          wr_pair
);
  localparam int OFFW = $clog2(LINE_BYTES);

  logic same_line;
  assign same_line = snoop_addr[AW-1:OFFW] == req_addr[AW-1:OFFW];

  AST_WRITE_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (res_valid && res_ok)); // R2
  AST_PAIR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pair |-> wr_en); // R3
  AST_INNER_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2) |=> !wr_en); // R3
  AST_RESULT_ONLY_AFTER_COND: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid && req_op[1])); // R10
  AST_COND_ALWAYS_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op[1]) |=> res_valid); // R10
  AST_COLLIDING_SNOOP_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3 && snoop_valid && same_line) |=> !res_ok); // R11
endmodule

bind dual_link_commit dlc_checker #(.AW(AW), .DW(DW), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_addr    (req_addr),
  .snoop_valid (snoop_valid),
  .snoop_addr  (snoop_addr),
  .res_valid   (res_valid),
  .res_ok      (res_ok),
  .wr_en       (wr_en),
  .wr_pair     (wr_pair)
);

// File: tb/dual_link_commit_test.sv
`timescale 1ns/1ps
module dual_link_commit_test;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk, rst_n;
  logic          req_valid, snoop_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr, snoop_addr, wr_addr0, wr_addr1;
  logic [DW-1:0] req_data, wr_data0, wr_data1;
  logic          res_valid, res_ok, wr_en, wr_pair;

  int n_run  = 0;
  int n_fail = 0;

  dual_link_commit #(.AW(AW), .DW(DW), .LINE_BYTES(32)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .res_valid(res_valid), .res_ok(res_ok),
    .wr_en(wr_en), .wr_pair(wr_pair), .wr_addr0(wr_addr0), .wr_data0(wr_data0),
    .wr_addr1(wr_addr1), .wr_data1(wr_data1));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        v;
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] d;
    logic        sv;
    logic [31:0] sa;
    logic        er;
    logic        eo;
    logic        ew;
    logic        ep;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 34;
  // op: 0 link, 1 pipelined link, 2 pipelined cond, 3 cond; A=0x100, B=0x200
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 32'h100, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd2},  // R2
    '{1'b1, 2'd3, 32'h100, 32'h11, 1'b0, 32'h0,   1'b1,1'b1,1'b1,1'b0, 8'd2},  // R2
    '{1'b1, 2'd0, 32'h100, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd3},  // R3
    '{1'b1, 2'd1, 32'h200, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd3},
    '{1'b1, 2'd2, 32'h200, 32'h22, 1'b0, 32'h0,   1'b1,1'b1,1'b0,1'b0, 8'd3},
    '{1'b1, 2'd3, 32'h100, 32'h33, 1'b0, 32'h0,   1'b1,1'b1,1'b1,1'b1, 8'd3},
    '{1'b1, 2'd0, 32'h100, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd4},  // R4
    '{1'b0, 2'd0, 32'h0,   32'h0,  1'b1, 32'h11C, 1'b0,1'b0,1'b0,1'b0, 8'd4},
    '{1'b1, 2'd3, 32'h100, 32'h0,  1'b0, 32'h0,   1'b1,1'b0,1'b0,1'b0, 8'd4},
    '{1'b1, 2'd0, 32'h100, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd4},
    '{1'b0, 2'd0, 32'h0,   32'h0,  1'b1, 32'h120, 1'b0,1'b0,1'b0,1'b0, 8'd4},
    '{1'b1, 2'd3, 32'h100, 32'h44, 1'b0, 32'h0,   1'b1,1'b1,1'b1,1'b0, 8'd4},
    '{1'b1, 2'd0, 32'h100, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd5},  // R5
    '{1'b1, 2'd1, 32'h200, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd5},
    '{1'b1, 2'd2, 32'h200, 32'h66, 1'b0, 32'h0,   1'b1,1'b1,1'b0,1'b0, 8'd5},
    '{1'b0, 2'd0, 32'h0,   32'h0,  1'b1, 32'h204, 1'b0,1'b0,1'b0,1'b0, 8'd5},
    '{1'b1, 2'd3, 32'h100, 32'h77, 1'b0, 32'h0,   1'b1,1'b0,1'b0,1'b0, 8'd5},
    '{1'b1, 2'd0, 32'h100, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd6},  // R6
    '{1'b1, 2'd1, 32'h200, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd6},
    '{1'b1, 2'd2, 32'h204, 32'h0,  1'b0, 32'h0,   1'b1,1'b0,1'b0,1'b0, 8'd6},
    '{1'b1, 2'd3, 32'h100, 32'h0,  1'b0, 32'h0,   1'b1,1'b0,1'b0,1'b0, 8'd6},
    '{1'b1, 2'd0, 32'h100, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd7},  // R7
    '{1'b1, 2'd3, 32'h104, 32'h0,  1'b0, 32'h0,   1'b1,1'b0,1'b0,1'b0, 8'd7},
    '{1'b1, 2'd3, 32'h100, 32'h0,  1'b0, 32'h0,   1'b1,1'b0,1'b0,1'b0, 8'd7},
    '{1'b1, 2'd1, 32'h200, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd8},  // R8
    '{1'b1, 2'd2, 32'h200, 32'h0,  1'b0, 32'h0,   1'b1,1'b0,1'b0,1'b0, 8'd8},
    '{1'b1, 2'd0, 32'h100, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd9},  // R9
    '{1'b1, 2'd1, 32'h200, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd9},
    '{1'b1, 2'd2, 32'h204, 32'h0,  1'b0, 32'h0,   1'b1,1'b0,1'b0,1'b0, 8'd9},
    '{1'b1, 2'd0, 32'h100, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd9},
    '{1'b1, 2'd3, 32'h100, 32'h55, 1'b0, 32'h0,   1'b1,1'b1,1'b1,1'b0, 8'd9},
    '{1'b1, 2'd0, 32'h100, 32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd11}, // R11
    '{1'b1, 2'd3, 32'h100, 32'h0,  1'b1, 32'h100, 1'b1,1'b0,1'b0,1'b0, 8'd11},
    '{1'b0, 2'd0, 32'h0,   32'h0,  1'b0, 32'h0,   1'b0,1'b0,1'b0,1'b0, 8'd10}  // R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample at the next negedge (after one posedge)
  task automatic step(input logic v, input logic [1:0] op, input logic [31:0] a,
                      input logic [31:0] d, input logic sv, input logic [31:0] sa);
    req_valid = v; req_op = op; req_addr = a; req_data = d;
    snoop_valid = sv; snoop_addr = sa;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R10 watchdog actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_data = '0;
    snoop_valid = 1'b0; snoop_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 res_valid at reset", {31'b0, res_valid}, 32'd0);
    check("R1 wr_en at reset", {31'b0, wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].v, VECS[i].op, VECS[i].a, VECS[i].d, VECS[i].sv, VECS[i].sa);
      check($sformatf("R%0d row %0d res_valid", VECS[i].rq, i), {31'b0, res_valid}, {31'b0, VECS[i].er});
      check($sformatf("R%0d row %0d res_ok", VECS[i].rq, i), {31'b0, res_ok}, {31'b0, VECS[i].eo});
      check($sformatf("R%0d row %0d wr_en", VECS[i].rq, i), {31'b0, wr_en}, {31'b0, VECS[i].ew});
      check($sformatf("R%0d row %0d wr_pair", VECS[i].rq, i), {31'b0, wr_pair}, {31'b0, VECS[i].ep});
    end

    // R2: single commit carries the request address and data
    step(1'b1, 2'd0, 32'h500, 32'h0, 1'b0, 32'h0);
    step(1'b1, 2'd3, 32'h500, 32'hCC, 1'b0, 32'h0);
    check("R2 wr_addr0", wr_addr0, 32'h500);
    check("R2 wr_data0", wr_data0, 32'hCC);

    // R3: pair commit routes buffered store to the second write
    step(1'b1, 2'd0, 32'h300, 32'h0, 1'b0, 32'h0);
    step(1'b1, 2'd1, 32'h440, 32'h0, 1'b0, 32'h0);
    step(1'b1, 2'd2, 32'h440, 32'hAAAA, 1'b0, 32'h0);
    check("R3 no write on inner", {31'b0, wr_en}, 32'd0);
    step(1'b1, 2'd3, 32'h300, 32'hBBBB, 1'b0, 32'h0);
    check("R3 pair", {30'b0, wr_en, wr_pair}, 32'd3);
    check("R3 wr_addr0", wr_addr0, 32'h300);
    check("R3 wr_data0", wr_data0, 32'hBBBB);
    check("R3 wr_addr1", wr_addr1, 32'h440);
    check("R3 wr_data1", wr_data1, 32'hAAAA);
    step(1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 32'h0);
    check("R10 strobe drops", {31'b0, res_valid}, 32'd0);

    // R1: reset in mid-sequence drops the reservation
    step(1'b1, 2'd0, 32'h100, 32'h0, 1'b0, 32'h0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 wr_en in reset", {31'b0, wr_en}, 32'd0);
    rst_n = 1'b1;
    step(1'b1, 2'd3, 32'h100, 32'h9, 1'b0, 32'h0);
    check("R1 cond after reset", {29'b0, res_valid, res_ok, wr_en}, 32'd4);
    step(1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule